// File: doc/BRIEF.md
# Scanline Sprite Evaluation Unit

This block chooses which sprites appear on the next video line. A 64-entry object store describes every sprite. Each entry is 16 bits wide and holds a vertical and a horizontal position. Sprites are fixed at 8x8 pixels. When the line strobe arrives, the block latches the line number and clears its 8-slot line buffer. It then reads the object store one entry per clock, from entry 0 up to entry 63. Each sprite whose rows cover the latched line is copied into the next free slot. The pixel pipeline reads the filled slots, the number of valid slots and an overflow flag. The overflow flag tells it that more than 8 sprites touched the line.

The object store sits outside the block. The block drives a read index, and the store must return that entry in the same cycle. The block does not draw pixels, generate any background layer or produce video timing.

Top module: `sprite_line_eval`

## Requirements
- R1: An entry carries the Y position in bits 15:8 and the X position in bits 7:0. A selected entry is copied into its slot unchanged, and slot k appears on `slot_data[16k+15:16k]`.
- R2: A sprite is selected when line ≥ Y and line − Y ≤ 7, using unsigned 8-bit values with no wrap-around. A Y greater than the line never selects, even if the 8-bit difference would be small.
- R3: At most 8 sprites are copied per scan, and `slot_count` stays between 0 and 8.
- R4: Entries are visited in ascending index order. The lowest-indexed selected sprite goes to slot 0 and the following ones fill the next slots.
- R5: A selected sprite found after all 8 slots are full sets `overflow` and is not copied. Exactly 8 selected sprites leave `overflow` low.
- R6: The clock edge that accepts the strobe clears every slot to zero and clears `slot_count` and `overflow`. Slots that stay unused read as zero.
- R7: A scan takes 64 cycles. `done` is high for exactly one cycle, in the 64th cycle after the edge that accepted the strobe. Results then hold until the next accepted strobe.
- R8: A strobe that arrives while a scan is running is ignored. The running scan keeps its latched line and its timing.
- R9: While reset is held, `slot_count` is 0, `overflow` and `done` are low, and all slots are zero.
- R10: `oam_addr` gives the index being evaluated, and `oam_data` must hold that entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_num | input | 8 | Line to evaluate, sampled together with the strobe |
| line_start | input | 1 | Start-of-line strobe |
| oam_addr | output | 6 | Index of the object store entry being read |
| oam_data | input | 16 | Entry at `oam_addr` ({Y, X}) |
| slot_data | output | 128 | The 8 line buffer slots, slot k in bits 16k+15:16k |
| slot_count | output | 4 | Number of valid slots, 0 to 8 |
| overflow | output | 1 | More than 8 sprites touched the line |
| done | output | 1 | One-cycle pulse when the scan ends |

## Verification
If the scan index slips or the state gets stuck, `done` moves away from its fixed 64-cycle mark or never rises. That shows up at the first scan after the fault. A wrong range test or a miscounted slot pointer shows up at the end of that line, as a wrong `slot_count`, a slot holding the wrong entry or a missing overflow. The results stay frozen once the scan ends, so each of these faults is visible in the cycle `done` rises and stays visible until the next strobe. A strobe that is not ignored during a scan shows up as an early or shifted `done`, or as results computed for the wrong line.

// File: rtl/sle_pkg.sv
package sle_pkg;

    parameter int OBJ_COUNT  = 64;
    parameter int SLOT_COUNT = 8;
    parameter int COORD_W    = 8;
    parameter int SPR_HEIGHT = 8;

    localparam int ENTRY_W = 2 * COORD_W;

    typedef struct packed {
        logic [COORD_W-1:0] ypos;
        logic [COORD_W-1:0] xpos;
    } obj_t;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_state_t;

    // True when the sprite's rows cover the given line, without wrap-around.
    function automatic logic covers_line(input logic [COORD_W-1:0] line,
                                         input logic [COORD_W-1:0] ypos);
        logic [COORD_W:0] diff;
        diff = {1'b0, line} - {1'b0, ypos};
        return !diff[COORD_W] && (diff[COORD_W-1:0] < COORD_W'(SPR_HEIGHT));
    endfunction

endpackage

// File: rtl/sle_scan_ctrl.sv
module sle_scan_ctrl
    import sle_pkg::*;
#(
    parameter int OBJS = OBJ_COUNT,
    localparam int IDX_W = $clog2(OBJS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic [COORD_W-1:0] line_in,
    output logic               busy,
    output logic               clear,
    output logic [IDX_W-1:0]   idx,
    output logic [COORD_W-1:0] line_q,
    output logic               done
);

    scan_state_t state_q;

    assign busy  = (state_q == SC_SCAN);
    assign clear = line_start && (state_q == SC_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SC_IDLE;
            idx     <= '0;
            line_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                SC_IDLE: begin
                    if (line_start) begin
                        state_q <= SC_SCAN;
                        idx     <= '0;
                        line_q  <= line_in;
                    end
                end
                SC_SCAN: begin
                    if (idx == IDX_W'(OBJS - 1)) begin
                        state_q <= SC_IDLE;
                        idx     <= '0;
                        done    <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state_q <= SC_IDLE;
            endcase
        end
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_scan_enters: assert property (@(posedge clk) disable iff (rst)
        (state_q == SC_IDLE && line_start) |=> (busy && idx == '0));

    a_r8_strobe_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && line_start) |=> $stable(line_q));

endmodule

// File: rtl/sle_range_chk.sv
module sle_range_chk
    import sle_pkg::*;
(
    input  logic               en,
    input  logic [COORD_W-1:0] line,
    input  obj_t               entry,
    output logic               hit
);

    assign hit = en && covers_line(line, entry.ypos);

endmodule

// File: rtl/sle_slot_buf.sv
module sle_slot_buf
    import sle_pkg::*;
#(
    parameter int SLOTS = SLOT_COUNT,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     hit,
    input  obj_t                     entry_in,
    output logic [SLOTS*ENTRY_W-1:0] slots_flat,
    output logic [CNT_W-1:0]         count,
    output logic                     overflow
);

    obj_t slot_q [SLOTS];
    logic full;
    logic take;

    assign full = (count == CNT_W'(SLOTS));
    assign take = hit && !full;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                slot_q[s] <= '0;
            end else if (take && count == CNT_W'(s)) begin
                slot_q[s] <= entry_in;
            end
        end
        assign slots_flat[s*ENTRY_W +: ENTRY_W] = slot_q[s];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (take) begin
                count <= count + 1'b1;
            end
            if (hit && full) begin
                overflow <= 1'b1;
            end
        end
    end

    a_r3_count_cap: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(SLOTS));

    a_r5_overflow_when_full: assert property (@(posedge clk) disable iff (rst)
        overflow |-> full);

    a_r6_clear_effect: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0 && !overflow));

    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
    import sle_pkg::*;
#(
    parameter int OBJS  = OBJ_COUNT,
    parameter int SLOTS = SLOT_COUNT,
    localparam int IDX_W = $clog2(OBJS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [COORD_W-1:0]       line_num,
    input  logic                     line_start,
    output logic [IDX_W-1:0]         oam_addr,
    input  logic [ENTRY_W-1:0]       oam_data,
    output logic [SLOTS*ENTRY_W-1:0] slot_data,
    output logic [CNT_W-1:0]         slot_count,
    output logic                     overflow,
    output logic                     done
);

    logic               busy;
    logic               clear;
    logic [COORD_W-1:0] line_q;
    logic               hit;
    obj_t               cur_obj;

    assign cur_obj = obj_t'(oam_data);

    sle_scan_ctrl #(.OBJS(OBJS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .line_in    (line_num),
        .busy       (busy),
        .clear      (clear),
        .idx        (oam_addr),
        .line_q     (line_q),
        .done       (done)
    );

    sle_range_chk u_range (
        .en    (busy),
        .line  (line_q),
        .entry (cur_obj),
        .hit   (hit)
    );

    sle_slot_buf #(.SLOTS(SLOTS)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .hit        (hit),
        .entry_in   (cur_obj),
        .slots_flat (slot_data),
        .count      (slot_count),
        .overflow   (overflow)
    );

    a_r7_results_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !line_start) |=> ($stable(slot_count) && $stable(overflow)
                                    && $stable(slot_data)));

    a_r10_addr_parked: assert property (@(posedge clk) disable iff (rst)
        done |-> (oam_addr == '0));

endmodule

// File: tb/sprite_line_eval_tb_top.sv
`timescale 1ns/1ps
module sprite_line_eval_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   line_num = '0;
    logic         line_start = 1'b0;
    logic [5:0]   oam_addr;
    logic [15:0]  oam_data;
    logic [127:0] slot_data;
    logic [3:0]   slot_count;
    logic         overflow;
    logic         done;

    logic [15:0] oam_mem [64];
    assign oam_data = oam_mem[oam_addr];   // same-cycle read (R10)

    always #2 clk = ~clk;

    sprite_line_eval dut_i (
        .clk(clk), .rst(rst), .line_num(line_num), .line_start(line_start),
        .oam_addr(oam_addr), .oam_data(oam_data), .slot_data(slot_data),
        .slot_count(slot_count), .overflow(overflow), .done(done)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct packed {
        logic [7:0] line;
        logic [3:0] pat;
        logic [3:0] cnt;
        logic       ovf;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{line: 8'd10,  pat: 4'd0, cnt: 4'd0, ovf: 1'b0},  // R2 nothing on line
        '{line: 8'd20,  pat: 4'd1, cnt: 4'd2, ovf: 1'b0},  // R2 R4 spread Y
        '{line: 8'd9,   pat: 4'd2, cnt: 4'd8, ovf: 1'b1},  // R5 all 64 hit
        '{line: 8'd10,  pat: 4'd0, cnt: 4'd0, ovf: 1'b0},  // R6 clear after full
        '{line: 8'd10,  pat: 4'd3, cnt: 4'd8, ovf: 1'b1},  // R4 odd entries only
        '{line: 8'd30,  pat: 4'd4, cnt: 4'd2, ovf: 1'b0},  // R2 edges 0,7,8,-1
        '{line: 8'd2,   pat: 4'd5, cnt: 4'd1, ovf: 1'b0},  // R2 no wrap, last idx
        '{line: 8'd100, pat: 4'd6, cnt: 4'd8, ovf: 1'b0}   // R5 exactly eight
    };

    function automatic logic [15:0] make_entry(input int pat, input int i);
        logic [7:0] y;
        logic [7:0] x;
        x = 8'(i * 7 + 3);
        case (pat)
            0: y = 8'd200;
            1: y = 8'(i * 4);
            2: y = 8'd5;
            3: y = (i % 2 == 1) ? 8'd3 : 8'd250;
            4: y = (i == 10) ? 8'd30 : (i == 20) ? 8'd23 :
                   (i == 30) ? 8'd22 : (i == 40) ? 8'd31 : 8'd255;
            5: y = (i == 63) ? 8'd0 : 8'd252;
            6: y = (i >= 56) ? 8'd100 : 8'd0;
            default: y = 8'd0;
        endcase
        return {y, x};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_pattern(input int pat);
        for (int i = 0; i < 64; i++) oam_mem[i] = make_entry(pat, i);
    endtask

    // Expected results from the requirement rules (R2..R6)
    logic [15:0] exp_slot [8];
    int          exp_cnt;
    logic        exp_ovf;

    task automatic predict(input int ln);
        exp_cnt = 0;
        exp_ovf = 1'b0;
        for (int s = 0; s < 8; s++) exp_slot[s] = '0;
        for (int i = 0; i < 64; i++) begin
            int y;
            y = int'(oam_mem[i][15:8]);
            if (ln >= y && ln - y <= 7) begin
                if (exp_cnt < 8) begin
                    exp_slot[exp_cnt] = oam_mem[i];
                    exp_cnt++;
                end else begin
                    exp_ovf = 1'b1;
                end
            end
        end
    endtask

    // Strobe, then watch done: low through 63 more negedges, high at the 64th, then low.
    task automatic run_scan(input logic [7:0] ln, input int glitch_at,
                            input logic [7:0] glitch_line);
        logic early;
        @(negedge clk);
        line_num   = ln;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        early = 1'b0;
        for (int k = 2; k <= 64; k++) begin
            @(negedge clk);
            if (done) early = 1'b1;
            line_start = (k == glitch_at);
            if (k == glitch_at) line_num = glitch_line;
        end
        check("R7", "done early", 32'(early), 32'd0);
        @(negedge clk);
        line_start = 1'b0;
        check("R7", "done at cycle 64", 32'(done), 32'd1);
        @(negedge clk);
        check("R7", "done single cycle", 32'(done), 32'd0);
    endtask

    task automatic check_results(input string req);
        check(req, "slot_count", 32'(slot_count), 32'(exp_cnt));
        check(req, "overflow", 32'(overflow), 32'(exp_ovf));
        for (int s = 0; s < 8; s++)
            check("R1", $sformatf("slot %0d", s), 32'(slot_data[s*16 +: 16]),
                  32'(exp_slot[s]));
    endtask

    initial begin
        load_pattern(0);
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", "count in reset", 32'(slot_count), 32'd0);
        check("R9", "overflow in reset", 32'(overflow), 32'd0);
        check("R9", "done in reset", 32'(done), 32'd0);
        check("R9", "slots in reset", 32'(|slot_data), 32'd0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            load_pattern(int'(VECS[v].pat));
            predict(int'(VECS[v].line));
            check("R3", "table count", 32'(exp_cnt), 32'(VECS[v].cnt));
            check("R5", "table overflow", 32'(exp_ovf), 32'(VECS[v].ovf));
            run_scan(VECS[v].line, 0, 8'd0);
            check_results("R4");
            repeat (5) @(negedge clk);
            check("R7", "count held", 32'(slot_count), 32'(exp_cnt));
        end

        // R8: strobe for a line with no sprites arrives mid-scan
        load_pattern(2);
        predict(9);
        run_scan(8'd9, 30, 8'd100);
        check("R8", "count after ignored strobe", 32'(slot_count), 32'd8);
        check("R8", "overflow after ignored strobe", 32'(overflow), 32'd1);
        check_results("R8");

        // R9: reset after a full result clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9", "count after reset", 32'(slot_count), 32'd0);
        check("R9", "overflow after reset", 32'(overflow), 32'd0);
        check("R9", "slots after reset", 32'(|slot_data), 32'd0);
        rst = 1'b0;

        // R6 R2: back-to-back scan right after reset, single hit at index 63
        load_pattern(5);
        predict(2);
        run_scan(8'd2, 0, 8'd0);
        check_results("R6");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule